// File: doc/BRIEF.md
# Paged receive ring buffer manager

This block places incoming frames into a circular receive area of local byte memory. The area is split into 256-byte pages and runs from a programmable first page up to, but not including, a programmable limit page; the page after the last one wraps back to the first. The block holds the page where the next frame will start. The host owns a boundary page that marks the oldest data it has not read yet.

A frame arrives as a byte stream with first-byte and last-byte markers, plus two status inputs that are valid with the last byte. The bytes are written from offset 4 of the current page onward. Once the frame has ended without running into the boundary page, four header bytes are written at offsets 0 to 3 of the page where the frame began. These hold the status, the page where the next frame will begin, and the stored byte count. The current page then advances.

A frame that would need the boundary page is abandoned: it raises overwrite and missed-packet events, and neither the header nor the current page changes. In monitor mode the block stores nothing and reports every frame as missed.

Top module: `rx_ring_mgr`

## Requirements
- R1: The first data byte of a stored frame is written at offset 4 of the current page. Each following byte goes to the next offset in turn.
- R2: After the byte at offset 255, writing continues at offset 0 of the next page. The page after (limit page - 1) is the first page. Every write stays inside the ring.
- R3: After a successful frame, exactly four header writes follow. They go to offsets 0, 1, 2 and 3 of the page where the frame began, in that order.
- R4: Header byte 0 is the status byte. Bit 0 copies `rx_ok`, bit 5 copies `rx_grp`, and all other bits are 0.
- R5: Header bytes 2 and 3 hold the data byte count plus 4, low byte first. A stored frame of L bytes causes L + 4 memory writes in total.
- R6: Header byte 1 holds the next-packet page. This is the ring page that follows the last page holding frame data, including when the last byte sits at offset 255.
- R7: After a successful store, `cur_page` changes to the next-packet page in the same cycle as the last header write. `ev_rcvd` pulses for exactly one cycle at that point.
- R8: Each time a next page is computed (at a page crossing, or at frame end), it is compared with `bnd_page`. If they are equal, `ev_ovw` and `ev_missed` pulse together for one cycle. After that the frame writes nothing more, no header is written, and `cur_page` keeps its value.
- R9: While `mon_mode` is high, a frame causes no memory writes. It gives one `ev_missed` pulse and no `ev_rcvd` pulse.
- R10: While reset is held, `mem_we`, all event outputs and `cur_page` are 0.
- R11: A `cur_wr_en` pulse loads `cur_wr_data` into `cur_page`. An advance at the end of a header takes priority over a load in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_start_page | input | PAGE_W | First page of the ring |
| cfg_stop_page | input | PAGE_W | Page just past the ring |
| bnd_page | input | PAGE_W | Host boundary page (oldest unread) |
| mon_mode | input | 1 | Monitor mode: count frames, store nothing |
| cur_wr_en | input | 1 | Load the current page |
| cur_wr_data | input | PAGE_W | Value to load into the current page |
| rx_valid | input | 1 | Byte valid |
| rx_sof | input | 1 | Marks the first byte of a frame |
| rx_eof | input | 1 | Marks the last byte of a frame |
| rx_data | input | 8 | Frame byte |
| rx_ok | input | 1 | Frame error-free (valid with the last byte) |
| rx_grp | input | 1 | Accepted by group match (valid with the last byte) |
| mem_we | output | 1 | Memory byte write enable |
| mem_addr | output | PAGE_W+OFS_W | Memory byte address {page, offset} |
| mem_wdata | output | 8 | Memory write data |
| cur_page | output | PAGE_W | Current receive page |
| ev_rcvd | output | 1 | Frame stored (one-cycle pulse) |
| ev_ovw | output | 1 | Ring overwrite detected (one-cycle pulse) |
| ev_missed | output | 1 | Frame not stored (one-cycle pulse) |

## Verification
Two decisions can fall in the same cycle: the page crossing after offset 255 and the end of the frame. Both use a single next-page step. Frames of 252 and 253 bytes put the last byte exactly at offset 255, or one byte past it. The bench compares the header's next-packet page and the new current page with ring arithmetic worked out on its own. The boundary check can also coincide with the frame's last byte. Sweeps over every current-page and boundary pairing in a three-page ring provoke this case, and the bench judges it by the write count, the untouched header bytes and the event pulses.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int unsigned CNT_W = 16;
  localparam int unsigned HDR_BYTES = 4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_STORE,
    ST_DROP,
    ST_HDR
  } rxr_state_e;
endpackage

// File: rtl/rxr_page_step.sv
module rxr_page_step #(
  parameter int unsigned PAGE_W = 8
) (
  input  logic [PAGE_W-1:0] page,
  input  logic [PAGE_W-1:0] first_pg,
  input  logic [PAGE_W-1:0] limit_pg,
  input  logic [PAGE_W-1:0] guard_pg,
  output logic [PAGE_W-1:0] nxt,
  output logic              hit_guard
);
  logic [PAGE_W-1:0] inc;

  always_comb begin
    inc       = page + 1'b1;
    nxt       = (inc == limit_pg) ? first_pg : inc;
    hit_guard = (nxt == guard_pg);
  end
endmodule

// File: rtl/rxr_hdr_fmt.sv
module rxr_hdr_fmt #(
  parameter int unsigned PAGE_W = 8
) (
  input  logic [1:0]              idx,
  input  logic                    ok,
  input  logic                    grp,
  input  logic [PAGE_W-1:0]       np,
  input  logic [rxr_pkg::CNT_W-1:0] cnt,
  output logic [7:0]              hbyte
);
  always_comb begin
    case (idx)
      2'd0:    hbyte = {2'b00, grp, 4'b0000, ok};
      2'd1:    hbyte = 8'(np);
      2'd2:    hbyte = cnt[7:0];
      default: hbyte = cnt[15:8];
    endcase
  end
endmodule

// File: rtl/rx_ring_mgr.sv
module rx_ring_mgr #(
  parameter int unsigned PAGE_W = 8,
  parameter int unsigned OFS_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [PAGE_W-1:0]       cfg_start_page,
  input  logic [PAGE_W-1:0]       cfg_stop_page,
  input  logic [PAGE_W-1:0]       bnd_page,
  input  logic                    mon_mode,
  input  logic                    cur_wr_en,
  input  logic [PAGE_W-1:0]       cur_wr_data,
  input  logic                    rx_valid,
  input  logic                    rx_sof,
  input  logic                    rx_eof,
  input  logic [7:0]              rx_data,
  input  logic                    rx_ok,
  input  logic                    rx_grp,
  output logic                    mem_we,
  output logic [PAGE_W+OFS_W-1:0] mem_addr,
  output logic [7:0]              mem_wdata,
  output logic [PAGE_W-1:0]       cur_page,
  output logic                    ev_rcvd,
  output logic                    ev_ovw,
  output logic                    ev_missed
);
  import rxr_pkg::*;

  localparam int unsigned AW = PAGE_W + OFS_W;
  localparam logic [OFS_W-1:0] DATA_OFS = OFS_W'(HDR_BYTES);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_s1, rst_s2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  rxr_state_e        st_q, st_d;
  logic [PAGE_W-1:0] cur_q, cur_d, orig_q, orig_d, wrp_q, wrp_d, np_q, np_d;
  logic [OFS_W-1:0]  off_q, off_d;
  logic [CNT_W-1:0]  len_q, len_d;
  logic [1:0]        idx_q, idx_d;
  logic              ok_q, ok_d, grp_q, grp_d;
  logic              we_q, we_d, rcvd_q, rcvd_d, ovw_q, ovw_d, miss_q, miss_d;
  logic [AW-1:0]     addr_q, addr_d;
  logic [7:0]        wdat_q, wdat_d;

  logic [PAGE_W-1:0] sel_page, step_pg;
  logic [OFS_W-1:0]  sel_off;
  logic              step_full, take, pg_end;
  logic [7:0]        hdr_byte;

  assign sel_page = (st_q == ST_IDLE) ? cur_q : wrp_q;
  assign sel_off  = (st_q == ST_IDLE) ? DATA_OFS : off_q;
  assign pg_end   = &sel_off;
  assign take     = rx_valid && (((st_q == ST_IDLE) && rx_sof && !mon_mode) ||
                                 (st_q == ST_STORE));

  rxr_page_step #(.PAGE_W(PAGE_W)) u_step (
    .page     (sel_page),
    .first_pg (cfg_start_page),
    .limit_pg (cfg_stop_page),
    .guard_pg (bnd_page),
    .nxt      (step_pg),
    .hit_guard(step_full)
  );

  rxr_hdr_fmt #(.PAGE_W(PAGE_W)) u_hdr (
    .idx  (idx_q),
    .ok   (ok_q),
    .grp  (grp_q),
    .np   (np_q),
    .cnt  (len_q + CNT_W'(HDR_BYTES)),
    .hbyte(hdr_byte)
  );

  always_comb begin
    st_d   = st_q;   cur_d  = cur_q;  orig_d = orig_q; wrp_d = wrp_q;
    np_d   = np_q;   off_d  = off_q;  len_d  = len_q;  idx_d = idx_q;
    ok_d   = ok_q;   grp_d  = grp_q;  addr_d = addr_q; wdat_d = wdat_q;
    we_d   = 1'b0;   rcvd_d = 1'b0;   ovw_d  = 1'b0;   miss_d = 1'b0;

    if (cur_wr_en) cur_d = cur_wr_data;

    if (take) begin
      we_d   = 1'b1;
      addr_d = {sel_page, sel_off};
      wdat_d = rx_data;
      len_d  = (st_q == ST_IDLE) ? CNT_W'(1) : len_q + 1'b1;
      if (st_q == ST_IDLE) orig_d = cur_q;
      if (pg_end || rx_eof) begin
        if (step_full) begin
          ovw_d  = 1'b1;
          miss_d = 1'b1;
          st_d   = rx_eof ? ST_IDLE : ST_DROP;
        end else if (rx_eof) begin
          st_d  = ST_HDR;
          idx_d = 2'd0;
          np_d  = step_pg;
          ok_d  = rx_ok;
          grp_d = rx_grp;
        end else begin
          wrp_d = step_pg;
          off_d = '0;
          st_d  = ST_STORE;
        end
      end else begin
        wrp_d = sel_page;
        off_d = sel_off + 1'b1;
        st_d  = ST_STORE;
      end
    end

    case (st_q)
      ST_IDLE: begin
        if (rx_valid && rx_sof && mon_mode) begin
          miss_d = 1'b1;
          if (!rx_eof) st_d = ST_DROP;
        end
      end
      ST_DROP: begin
        if (rx_valid && rx_eof) st_d = ST_IDLE;
      end
      ST_HDR: begin
        we_d   = 1'b1;
        addr_d = {orig_q, OFS_W'(idx_q)};
        wdat_d = hdr_byte;
        idx_d  = idx_q + 1'b1;
        if (idx_q == 2'd3) begin
          cur_d  = np_q;
          rcvd_d = 1'b1;
          st_d   = ST_IDLE;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s2) begin
    if (!rst_s2) begin
      st_q <= ST_IDLE; cur_q <= '0; orig_q <= '0; wrp_q <= '0; np_q <= '0;
      off_q <= '0; len_q <= '0; idx_q <= '0; ok_q <= 1'b0; grp_q <= 1'b0;
      we_q <= 1'b0; rcvd_q <= 1'b0; ovw_q <= 1'b0; miss_q <= 1'b0;
      addr_q <= '0; wdat_q <= '0;
    end else begin
      st_q <= st_d; cur_q <= cur_d; orig_q <= orig_d; wrp_q <= wrp_d; np_q <= np_d;
      off_q <= off_d; len_q <= len_d; idx_q <= idx_d; ok_q <= ok_d; grp_q <= grp_d;
      we_q <= we_d; rcvd_q <= rcvd_d; ovw_q <= ovw_d; miss_q <= miss_d;
      addr_q <= addr_d; wdat_q <= wdat_d;
    end
  end

  assign mem_we    = we_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = wdat_q;
  assign cur_page  = cur_q;
  assign ev_rcvd   = rcvd_q;
  assign ev_ovw    = ovw_q;
  assign ev_missed = miss_q;
endmodule

// File: rtl/rx_ring_chk.sv
module rx_ring_chk #(
  parameter int unsigned PAGE_W = 8,
  parameter int unsigned OFS_W  = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [PAGE_W-1:0]       cfg_start_page,
  input logic [PAGE_W-1:0]       cfg_stop_page,
  input logic                    cur_wr_en,
  input logic                    mem_we,
  input logic [PAGE_W+OFS_W-1:0] mem_addr,
  input logic [PAGE_W-1:0]       cur_page,
  input logic                    ev_rcvd,
  input logic                    ev_ovw,
  input logic                    ev_missed
);
  logic [PAGE_W-1:0] wr_pg;
  assign wr_pg = mem_addr[PAGE_W+OFS_W-1:OFS_W];

  // R8
  ovw_with_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ovw |-> ev_missed);

  // R7
  rcvd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rcvd |=> !ev_rcvd);

  // R3
  hdr_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rcvd |-> (mem_we && mem_addr[OFS_W-1:0] == OFS_W'(3)));

  // R11
  cur_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_page != $past(cur_page)) |-> ($past(cur_wr_en) || ev_rcvd));

  // R2
  in_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (wr_pg >= cfg_start_page && wr_pg < cfg_stop_page));

  // R8
  ovw_keeps_cur_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ovw && !$past(cur_wr_en)) |-> (cur_page == $past(cur_page)));
endmodule

bind rx_ring_mgr rx_ring_chk #(.PAGE_W(PAGE_W), .OFS_W(OFS_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_start_page(cfg_start_page),
  .cfg_stop_page (cfg_stop_page),
  .cur_wr_en     (cur_wr_en),
  .mem_we        (mem_we),
  .mem_addr      (mem_addr),
  .cur_page      (cur_page),
  .ev_rcvd       (ev_rcvd),
  .ev_ovw        (ev_ovw),
  .ev_missed     (ev_missed)
);

// File: tb/tb_rx_ring_mgr.sv
`timescale 1ns/1ps
module tb_rx_ring_mgr;
  localparam int PW = 8, OW = 8;
  localparam int FIRST = 2, LIMIT = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic [PW-1:0] cfg_start_page, cfg_stop_page, bnd_page, cur_wr_data;
  logic mon_mode, cur_wr_en, rx_valid, rx_sof, rx_eof, rx_ok, rx_grp;
  logic [7:0] rx_data;
  logic mem_we, ev_rcvd, ev_ovw, ev_missed;
  logic [PW+OW-1:0] mem_addr;
  logic [7:0] mem_wdata;
  logic [PW-1:0] cur_page;

  always #10 clk = ~clk;

  rx_ring_mgr #(.PAGE_W(PW), .OFS_W(OW)) dut (.*);

  int total = 0, bad = 0;
  int n_we, n_rcvd, n_ovw, n_miss;
  logic [7:0] bm [0:2047];

  always @(negedge clk) begin
    if (mem_we) begin bm[mem_addr[10:0]] = mem_wdata; n_we++; end
    if (ev_rcvd) n_rcvd++;
    if (ev_ovw) n_ovw++;
    if (ev_missed) n_miss++;
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int adv(input int p, input int n);
    int q = p;
    for (int k = 0; k < n; k++) q = (q + 1 == LIMIT) ? FIRST : q + 1;
    return q;
  endfunction

  task automatic send(input int len, input bit ok, input bit grp);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_sof = (i == 0); rx_eof = (i == len - 1);
      rx_data = 8'(i * 7 + len); rx_ok = ok; rx_grp = grp;
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic load_cur(input int p);
    @(negedge clk); cur_wr_en = 1'b1; cur_wr_data = PW'(p);
    @(negedge clk); cur_wr_en = 1'b0;
    chk("R11 cur load", int'(cur_page), p);
  endtask

  task automatic run(input int cur, input int bnd, input int len);
    int last_rel, ovf, np, errs, pos;
    bit ok, grp;
    bnd_page = PW'(bnd);
    load_cur(cur);
    for (int k = 0; k < 4; k++) bm[cur * 256 + k] = 8'hEE;
    n_we = 0; n_rcvd = 0; n_ovw = 0; n_miss = 0;
    ok = len[0]; grp = len[1];
    send(len, ok, grp);
    last_rel = (len + 3) / 256;
    ovf = 0;
    for (int j = 1; j <= last_rel + 1; j++)
      if (ovf == 0 && adv(cur, j) == bnd) ovf = j;
    if (ovf != 0) begin
      chk("R8 writes before drop", n_we, (len < 256 * ovf - 4) ? len : 256 * ovf - 4);
      chk("R8 ovw pulses", n_ovw, 1);
      chk("R8 missed pulses", n_miss, 1);
      chk("R8 no rcvd", n_rcvd, 0);
      chk("R8 cur kept", int'(cur_page), cur);
      chk("R8 hdr untouched", int'(bm[cur * 256]), 8'hEE);
    end else begin
      np = adv(cur, last_rel + 1);
      chk("R5 write count", n_we, len + 4);
      chk("R7 rcvd pulses", n_rcvd, 1);
      chk("R8 no ovw", n_ovw + n_miss, 0);
      chk("R7 cur advanced", int'(cur_page), np);
      chk("R4 status byte", int'(bm[cur * 256]), (int'(grp) << 5) | int'(ok));
      chk("R6 next page", int'(bm[cur * 256 + 1]), np);
      chk("R5 count low", int'(bm[cur * 256 + 2]), (len + 4) & 255);
      chk("R5 count high", int'(bm[cur * 256 + 3]), (len + 4) >> 8);
      errs = 0;
      for (int i = 0; i < len; i++) begin
        pos = 4 + i;
        if (bm[adv(cur, pos / 256) * 256 + pos % 256] != 8'(i * 7 + len)) errs++;
      end
      chk("R1 R2 data placement", errs, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lens [10] = '{1, 2, 60, 251, 252, 253, 300, 508, 509, 600};
    rst_n = 1'b0;
    cfg_start_page = PW'(FIRST); cfg_stop_page = PW'(LIMIT); bnd_page = PW'(FIRST);
    mon_mode = 1'b0; cur_wr_en = 1'b0; cur_wr_data = '0;
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_data = '0; rx_ok = 1'b0; rx_grp = 1'b0;
    for (int k = 0; k < 2048; k++) bm[k] = 8'h00;
    repeat (3) @(negedge clk);
    chk("R10 reset we", int'(mem_we), 0);
    chk("R10 reset events", int'(ev_rcvd) + int'(ev_ovw) + int'(ev_missed), 0);
    chk("R10 reset cur", int'(cur_page), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    for (int c = FIRST; c < LIMIT; c++)
      for (int b = FIRST; b < LIMIT; b++)
        if (b != c)
          for (int li = 0; li < 10; li++) run(c, b, lens[li]);

    // monitor mode
    mon_mode = 1'b1;
    for (int li = 0; li < 3; li++) begin
      bnd_page = PW'(FIRST);
      load_cur(3);
      n_we = 0; n_rcvd = 0; n_ovw = 0; n_miss = 0;
      send(lens[li * 3], 1'b1, 1'b0);
      chk("R9 no writes", n_we, 0);
      chk("R9 one missed", n_miss, 1);
      chk("R9 no rcvd/ovw", n_rcvd + n_ovw, 0);
      chk("R9 cur kept", int'(cur_page), 3);
    end
    mon_mode = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule